// File: doc/BRIEF.md
# ECC Error Exception Dispatcher

This block sits between the memory ECC checkers and the processor core. Whenever an uncorrectable ECC fault is seen in flash or in SRAM, the dispatcher is given one event on `err_valid`. The event carries the faulting address, the number of the bus master that issued the access, and three tags:

- which memory faulted;
- whether the CPU issued the access;
- whether the access was an instruction fetch or a data transfer, and whether it was a read or a write.

For faults caused by the CPU, the block picks the processor response from the external-interrupt enable and the machine-check enable. The response is one of:

- a data-storage exception;
- an instruction-storage exception;
- a machine-check exception;
- a move into a sticky checkstop.

Faults from any other master are reported only through a small set of software registers and an interrupt request line.

A three-state machine tracks the processor condition:

- **RUN** is normal operation. An unhandled CPU fault moves RUN to **CHECKSTOP** (transition *halt*).
- **CHECKSTOP** is left only by reset.
- While `dbg_req` is high, CHECKSTOP moves to **DEBUG** (transition *enter_debug*).
- When `dbg_req` drops, DEBUG moves back to CHECKSTOP (transition *leave_debug*).

Reset forces RUN (transition *reset*). No exception is raised outside RUN.

Software enables reporting for each memory separately. The first reported fault is latched with its details, and the latch stays held until software clears the status with a write-one-to-clear.

Top module: `ecc_exc_dispatch`

## Requirements
- R1: The configuration register at address 0 holds the SRAM reporting enable in bit 0 and the flash reporting enable in bit 1. It reads back what was written, and every register reads zero after reset.
- R2: A fault in a memory whose enable is set sets that memory's status flag at address 1 (bit 0 SRAM, bit 1 flash) on the clock edge that samples it. A fault in a memory whose enable is clear sets no flag.
- R3: `irq` is high while any status flag is set together with its enable. Writing 1 to a status bit clears that bit. `ext_exc` equals `irq` while `vec9_en` is high and is low otherwise.
- R4: A fault from a non-CPU master (`err_cpu`=0) never raises `exc_valid` and never changes the state.
- R5: With `msr_ee`=1, a CPU data fault raises a one-cycle `exc_valid` with `exc_code`=2 and a CPU instruction fault raises one with code 3, whatever `msr_me` is. The pulse comes in the cycle after the sampling edge.
- R6: With `msr_ee`=0 and `msr_me`=1, a CPU fault of either access type raises `exc_valid` with `exc_code`=1.
- R7: With `msr_ee`=0 and `msr_me`=0, a CPU fault raises no exception and moves RUN to CHECKSTOP, so that `halted` is high from the next cycle.
- R8: CHECKSTOP is left only by reset. No fault seen in CHECKSTOP or DEBUG raises an exception.
- R9: In CHECKSTOP, `dbg_req`=1 moves to DEBUG (`debug_mode`=1, `halted`=0). In DEBUG, `dbg_req`=0 moves back to CHECKSTOP.
- R10: Storage exceptions for CPU faults are raised even when reporting for that memory is disabled.
- R11: The address register (address 2) and the detail register (address 3) hold the first reported fault while any status flag is set. The detail layout is: bit 0 write, bit 1 instruction, bit 2 flash, bits 15:8 master number. A fault that arrives on the same edge as a clear of all flags is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One uncorrectable fault event this cycle |
| err_flash | input | 1 | 1 = flash fault, 0 = SRAM fault |
| err_cpu | input | 1 | 1 = the CPU issued the access |
| err_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| err_write | input | 1 | 1 = write access |
| err_addr | input | ADDR_W | Faulting address |
| err_master | input | MST_W | Number of the issuing bus master |
| msr_ee | input | 1 | External-interrupt enable |
| msr_me | input | 1 | Machine-check enable |
| vec9_en | input | 1 | ECC vector enabled in the interrupt controller |
| dbg_req | input | 1 | Debug request level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to the interrupt controller |
| ext_exc | output | 1 | External exception signalled |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_code | output | 3 | Exception code (1 machine check, 2 data storage, 3 instruction storage) |
| halted | output | 1 | In CHECKSTOP |
| debug_mode | output | 1 | In DEBUG |

## Verification
The bench checks several cases, each tied to a specific mistake:

- **Non-CPU master with `msr_ee` set.** A design that ignored the master tag would raise a storage exception here.
- **`msr_me` set alongside `msr_ee`.** A design with the wrong priority would answer with code 1 instead of 2 or 3.
- **CPU faults with reporting disabled.** A design that gated exceptions on the enables would stay silent.
- **Second fault while a flag is pending.** A design that overwrote the details would report the wrong address.
- **Fault while halted or in debug.** A design that left CHECKSTOP on such a fault, or that stayed in DEBUG after `dbg_req` dropped, would show the wrong `halted` and `debug_mode` levels.

// File: rtl/ecc_exc_pkg.sv
package ecc_exc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CSTOP = 2'd1,
        ST_DEBUG = 2'd2
    } proc_state_t;

    localparam logic [2:0] CODE_MCHK  = 3'd1;
    localparam logic [2:0] CODE_DSTOR = 3'd2;
    localparam logic [2:0] CODE_ISTOR = 3'd3;

    localparam logic [1:0] RA_CFG  = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_ADDR = 2'd2;
    localparam logic [1:0] RA_INFO = 2'd3;
endpackage

// File: rtl/ecc_exc_fsm.sv
module ecc_exc_fsm
    import ecc_exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_err,
    input  logic       err_instr,
    input  logic       msr_ee,
    input  logic       msr_me,
    input  logic       dbg_req,
    output logic       exc_valid,
    output logic [2:0] exc_code,
    output logic       halted,
    output logic       debug_mode
);
    proc_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (cpu_err && !msr_ee && !msr_me) st_d = ST_CSTOP;
            ST_CSTOP: if (dbg_req) st_d = ST_DEBUG;
            ST_DEBUG: if (!dbg_req) st_d = ST_CSTOP;
            default:  st_d = ST_CSTOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_code  <= 3'd0;
        end else begin
            exc_valid <= 1'b0;
            exc_code  <= 3'd0;
            if (st_q == ST_RUN && cpu_err) begin
                if (msr_ee) begin
                    exc_valid <= 1'b1;
                    exc_code  <= err_instr ? CODE_ISTOR : CODE_DSTOR;
                end else if (msr_me) begin
                    exc_valid <= 1'b1;
                    exc_code  <= CODE_MCHK;
                end
            end
        end
    end

    assign halted     = (st_q == ST_CSTOP);
    assign debug_mode = (st_q == ST_DEBUG);

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted || debug_mode));
    assert_no_exc_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || debug_mode) |=> !exc_valid);
    assert_debug_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode && !dbg_req) |=> halted);
    assert_cstop_no_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> !exc_valid);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic              err_flash,
    input  logic              err_instr,
    input  logic              err_write,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [MST_W-1:0]  err_master,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int NMEM = 2;

    logic [NMEM-1:0]   cfg_q, flag_q, flag_kept, set_v, clr_v;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [MST_W-1:0]  cap_mst_q;
    logic              cap_wr_q, cap_instr_q, cap_flash_q;
    logic              take;

    generate
        for (genvar m = 0; m < NMEM; m++) begin : g_mem
            assign set_v[m] = err_valid && cfg_q[m] && (err_flash == (m == 1));
            assign clr_v[m] = reg_wr && reg_addr == RA_STAT && reg_wdata[m];
        end
    endgenerate

    assign flag_kept = flag_q & ~clr_v;
    assign take      = (|set_v) && (flag_kept == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            flag_q      <= '0;
            cap_addr_q  <= '0;
            cap_mst_q   <= '0;
            cap_wr_q    <= 1'b0;
            cap_instr_q <= 1'b0;
            cap_flash_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_CFG) cfg_q <= reg_wdata[NMEM-1:0];
            flag_q <= flag_kept | set_v;
            if (take) begin
                cap_addr_q  <= err_addr;
                cap_mst_q   <= err_master;
                cap_wr_q    <= err_write;
                cap_instr_q <= err_instr;
                cap_flash_q <= err_flash;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CFG:  reg_rdata = 32'(cfg_q);
            RA_STAT: reg_rdata = 32'(flag_q);
            RA_ADDR: reg_rdata = 32'(cap_addr_q);
            default: reg_rdata = (32'(cap_mst_q) << 8)
                                 | {29'd0, cap_flash_q, cap_instr_q, cap_wr_q};
        endcase
    end

    assign irq = |(flag_q & cfg_q);

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(err_valid || reg_wr));
    assert_first_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flag_q) && !(reg_wr && reg_addr == RA_STAT)) |=> $stable(cap_addr_q));
    assert_disabled_noflag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && cfg_q == '0) |=> $stable(flag_q));
endmodule

// File: rtl/ecc_exc_dispatch.sv
module ecc_exc_dispatch #(
    parameter int ADDR_W = 32,
    parameter int MST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic              err_flash,
    input  logic              err_cpu,
    input  logic              err_instr,
    input  logic              err_write,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [MST_W-1:0]  err_master,
    input  logic              msr_ee,
    input  logic              msr_me,
    input  logic              vec9_en,
    input  logic              dbg_req,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              ext_exc,
    output logic              exc_valid,
    output logic [2:0]        exc_code,
    output logic              halted,
    output logic              debug_mode
);
    logic cpu_err;
    assign cpu_err = err_valid && err_cpu;

    ecc_exc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_err    (cpu_err),
        .err_instr  (err_instr),
        .msr_ee     (msr_ee),
        .msr_me     (msr_me),
        .dbg_req    (dbg_req),
        .exc_valid  (exc_valid),
        .exc_code   (exc_code),
        .halted     (halted),
        .debug_mode (debug_mode)
    );

    ecc_err_capture #(.ADDR_W(ADDR_W), .MST_W(MST_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_valid  (err_valid),
        .err_flash  (err_flash),
        .err_instr  (err_instr),
        .err_write  (err_write),
        .err_addr   (err_addr),
        .err_master (err_master),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    assign ext_exc = irq && vec9_en;

    assert_noncpu_no_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_cpu) |=> !exc_valid);
endmodule

// File: tb/ecc_exc_dispatch_tb.sv
module ecc_exc_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        err_valid = 0, err_flash = 0, err_cpu = 0, err_instr = 0, err_write = 0;
    logic [31:0] err_addr = 0;
    logic [3:0]  err_master = 0;
    logic        msr_ee = 0, msr_me = 0, vec9_en = 0, dbg_req = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, ext_exc, exc_valid, halted, debug_mode;
    logic [2:0]  exc_code;

    int total = 0, bad = 0;
    logic [2:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_exc_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_flash(err_flash),
        .err_cpu(err_cpu), .err_instr(err_instr), .err_write(err_write),
        .err_addr(err_addr), .err_master(err_master), .msr_ee(msr_ee), .msr_me(msr_me),
        .vec9_en(vec9_en), .dbg_req(dbg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .ext_exc(ext_exc),
        .exc_valid(exc_valid), .exc_code(exc_code), .halted(halted), .debug_mode(debug_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops an expected exception for every observed pulse
    always @(negedge clk) begin
        if (rst_n && exc_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R4/R8 unexpected exception actual=%0d expected=none", exc_code);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if (exc_code !== e) begin
                    bad++;
                    $display("FAIL R5/R6 exception code actual=%0d expected=%0d", exc_code, e);
                end
            end
        end
    end

    task automatic send_err(input logic fl, input logic cpu, input logic ins, input logic wr,
                            input logic [31:0] a, input logic [3:0] m, input logic [2:0] exp_code,
                            input logic exp_exc, input string req);
        if (exp_exc) exp_q.push_back(exp_code);
        err_valid = 1; err_flash = fl; err_cpu = cpu; err_instr = ins; err_write = wr;
        err_addr = a; err_master = m;
        @(negedge clk);
        err_valid = 0;
        @(negedge clk); #1;
        check({req, " pending exception drained"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk(2'd0, 0, "R1 cfg reset");
        rd_chk(2'd1, 0, "R1 status reset");
        rd_chk(2'd2, 0, "R1 addr reset");
        check("R3 irq reset", 32'(irq), 0);
        check("R7 halted reset", 32'(halted), 0);
        wr_reg(2'd0, 32'h3);
        rd_chk(2'd0, 32'h3, "R1 cfg readback");

        // R4 DMA data write fault in SRAM, ee=1
        msr_ee = 1; msr_me = 0;
        send_err(0, 0, 0, 1, 32'hA000_0010, 4'd5, 0, 0, "R4");
        rd_chk(2'd1, 32'h1, "R2 sram flag");
        check("R3 irq set", 32'(irq), 1);
        vec9_en = 1; #1;
        check("R3 ext_exc enabled", 32'(ext_exc), 1);
        vec9_en = 0; #1;
        check("R3 ext_exc masked", 32'(ext_exc), 0);

        // R5 CPU instruction fault in flash with flag already pending
        send_err(1, 1, 1, 0, 32'hB000_0020, 4'd0, 3'd3, 1, "R5 istor");
        rd_chk(2'd1, 32'h3, "R2 both flags");
        rd_chk(2'd2, 32'hA000_0010, "R11 first address kept");
        rd_chk(2'd3, 32'h501, "R11 first detail kept");

        // R3 write-one-to-clear
        @(negedge clk);
        wr_reg(2'd1, 32'h3);
        rd_chk(2'd1, 0, "R3 status cleared");
        check("R3 irq cleared", 32'(irq), 0);

        // R10/R5 reporting disabled, ee=1 me=1 data fault
        wr_reg(2'd0, 32'h0);
        msr_me = 1;
        send_err(0, 1, 0, 0, 32'hC000_0030, 4'd0, 3'd2, 1, "R5/R10 dstor");
        rd_chk(2'd1, 0, "R2 disabled no flag");
        check("R3 irq disabled", 32'(irq), 0);

        // R6 machine check, flash instruction read, flash reporting only
        wr_reg(2'd0, 32'h2);
        msr_ee = 0; msr_me = 1;
        send_err(1, 1, 1, 0, 32'hD000_0040, 4'd2, 3'd1, 1, "R6 mchk");
        rd_chk(2'd1, 32'h2, "R2 flash flag");
        rd_chk(2'd2, 32'hD000_0040, "R11 new address after clear");
        rd_chk(2'd3, 32'h206, "R11 detail layout");
        send_err(0, 1, 0, 0, 32'hD000_0050, 4'd2, 3'd1, 1, "R6 mchk data");
        rd_chk(2'd1, 32'h2, "R2 sram disabled no flag");

        // R7 checkstop
        msr_me = 0;
        send_err(0, 1, 0, 0, 32'hE000_0060, 4'd0, 0, 0, "R7 checkstop");
        check("R7 halted", 32'(halted), 1);
        msr_ee = 1;
        send_err(0, 1, 0, 0, 32'hE000_0070, 4'd0, 0, 0, "R8 fault in checkstop");
        check("R8 still halted", 32'(halted), 1);

        // R9 debug excursion
        dbg_req = 1;
        @(negedge clk); #1;
        check("R9 debug entered", 32'(debug_mode), 1);
        check("R9 halted low in debug", 32'(halted), 0);
        send_err(0, 1, 1, 0, 32'hE000_0080, 4'd0, 0, 0, "R8 fault in debug");
        check("R9 stays in debug", 32'(debug_mode), 1);
        dbg_req = 0;
        @(negedge clk); #1;
        check("R9 back to checkstop", 32'(halted), 1);
        check("R9 debug left", 32'(debug_mode), 0);

        // R8 only reset leaves checkstop
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; #1;
        check("R8 reset leaves checkstop", 32'(halted), 0);
        rd_chk(2'd0, 0, "R1 cfg after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule